// File: doc/BRIEF.md
# External Write Bus Sequencer

This block turns single write requests from a processor core into a timed sequence on an external bus. A request carries a 23-bit word address, a 16-bit data word and a space code that selects program, data or I/O space. Each request is accepted only while the sequencer is idle. The sequencer then drives the address, the data, an active-low write indication, one of two active-low strobes and one of three active-low space-select lines through a fixed series of phases. It answers with a one-cycle acknowledge.

Every phase is measured in bus cycles. One bus cycle lasts one to four core clocks, set by a divide code, so a slower divide stretches the whole sequence. A wait-state count lengthens only the write phase. An access that lands in a different 32K-word region from the previous access is preceded by a bank-switch cycle, during which nothing is strobed or selected. When no request is pending, the internal clock enable drops. It rises in the same cycle that a request appears, so waking up costs no cycles.

Top module: `ext_wr_seq`

## Requirements
- R1: While `rst` is high and afterwards with no request, `bus_rnw`, both strobes and all three select lines are high, while `bus_data_oe`, `req_ack` and `clk_en` are low.
- R2: With no wait states and a divide code of 0, an accepted write occupies exactly three bus cycles, in this order: a lead cycle (`bus_rnw` low, no strobe, `bus_data_oe` low), a write cycle (strobe low, data driven) and a trail cycle (strobe high, data still driven).
- R3: `cfg_wait` adds that many extra bus cycles to the write phase only. A code of 15 acts as 14. The lead and trail cycles stay one bus cycle long.
- R4: `cfg_div` codes 0, 1, 2 and 3 make one bus cycle last 1, 2, 3 and 4 core clocks. Every phase, including the lead, trail and bank-switch cycles, scales by this factor.
- R5: If address bits 22:15 of an access differ from those of the previous accepted access, one bank-switch bus cycle comes before the lead cycle. The first access after reset always gets one. During a bank-switch cycle `bus_rnw`, both strobes and all selects stay high. An access in the same region gets no bank-switch cycle.
- R6: Space code 0 (program) and code 1 (data) use `bus_mstrb_n`. Code 2 (I/O) uses `bus_iostrb_n`. The two strobes are never low together. From lead through trail, exactly one select is low: `bus_ps_n` for code 0, `bus_ds_n` for code 1, and `bus_is_n` for code 2. Code 3 is reserved and behaves as code 1.
- R7: `bus_data` carries the request data and `bus_data_oe` is high from the first write-phase clock through the last trail clock. The strobe is low only in the write phase, including its wait states.
- R8: A request is taken only when the sequencer is idle and `req_valid` is high. `req_ack` is high for exactly one core clock, which is the last clock of the trail cycle. Request inputs that change while a sequence runs do not affect `bus_addr` or `bus_data`.
- R9: `clk_en` is low when idle with `req_valid` low. It is high in the same cycle that `req_valid` rises in idle, and the lead (or bank) phase starts on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 2 | Bus clock divide code (factor = code + 1), sampled at accept |
| cfg_wait | input | 4 | Write-phase wait states (15 treated as 14), sampled at accept |
| req_valid | input | 1 | Write request present; held until acknowledge |
| req_addr | input | 23 | Request word address |
| req_data | input | 16 | Request write data |
| req_space | input | 2 | Space code: 0 program, 1 data, 2 I/O, 3 reserved |
| req_ack | output | 1 | One-clock acknowledge at the end of the trail cycle |
| bus_addr | output | 23 | External address of the current or last access |
| bus_data | output | 16 | External write data, zero when not driven |
| bus_data_oe | output | 1 | Data bus drive enable |
| bus_rnw | output | 1 | Read/write line, low during lead to trail |
| bus_mstrb_n | output | 1 | Memory strobe, active low |
| bus_iostrb_n | output | 1 | I/O strobe, active low |
| bus_ps_n | output | 1 | Program space select, active low |
| bus_ds_n | output | 1 | Data space select, active low |
| bus_is_n | output | 1 | I/O space select, active low |
| clk_en | output | 1 | Internal clock enable, low when idle |

## Verification
The hardest case to reach is a bank-switch cycle combined with a long write phase under a large divide factor, together with the change from a switching access to a non-switching one. At the ports, these depend on the hidden last-region register and on the latched configuration. The stimulus sweeps every divide code against a set of wait codes that includes 0, 14 and 15, across all three spaces. It changes the region on every other access, so each combination is followed by a same-region access. During each access the bench scrambles the request inputs after the first cycle, to show that they are ignored once the request has been accepted.

// File: rtl/ewb_pkg.sv
package ewb_pkg;
    localparam int ADDR_W     = 23;
    localparam int DATA_W     = 16;
    localparam int REGION_LSB = 15;
    localparam int REGION_W   = ADDR_W - REGION_LSB;
    localparam int WAIT_W     = 4;
    localparam int WAIT_MAX   = 14;
    localparam int DIV_W      = 2;

    typedef enum logic [1:0] {
        SP_PROG = 2'd0,
        SP_DATA = 2'd1,
        SP_IO   = 2'd2,
        SP_RSVD = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_BANK  = 3'd1,
        PH_LEAD  = 3'd2,
        PH_WRITE = 3'd3,
        PH_TRAIL = 3'd4
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        space_e            space;
    } wreq_t;

    typedef struct packed {
        logic [DIV_W-1:0]  div_code;
        logic [WAIT_W-1:0] wait_eff;
    } wcfg_t;

    function automatic logic [WAIT_W-1:0] clamp_wait(input logic [WAIT_W-1:0] w);
        if (w > WAIT_W'(WAIT_MAX))
            return WAIT_W'(WAIT_MAX);
        return w;
    endfunction

    function automatic logic space_is_io(input space_e s);
        return s == SP_IO;
    endfunction

    function automatic logic [REGION_W-1:0] region_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:REGION_LSB];
    endfunction
endpackage

// File: rtl/ewb_clk_div.sv
module ewb_clk_div #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div_code);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ewb_bank_track.sv
module ewb_bank_track
    import ewb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    output logic              need_switch
);
    logic [REGION_W-1:0] last_region;
    logic                last_valid;

    assign need_switch = !last_valid || (region_of(addr) != last_region);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_region <= '0;
            last_valid  <= 1'b0;
        end else if (accept) begin
            last_region <= region_of(addr);
            last_valid  <= 1'b1;
        end
    end
endmodule

// File: rtl/ewb_seq_fsm.sv
module ewb_seq_fsm
    import ewb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              tick,
    input  logic              need_bank,
    input  logic [WAIT_W-1:0] wait_eff,
    output phase_e            phase,
    output logic              accept,
    output logic              ack
);
    logic [WAIT_W-1:0] wcnt;

    assign accept = (phase == PH_IDLE) && req_valid;
    assign ack    = (phase == PH_TRAIL) && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            wcnt  <= '0;
        end else begin
            case (phase)
                PH_IDLE:  if (req_valid) phase <= need_bank ? PH_BANK : PH_LEAD;
                PH_BANK:  if (tick) phase <= PH_LEAD;
                PH_LEAD:  if (tick) begin
                              phase <= PH_WRITE;
                              wcnt  <= wait_eff;
                          end
                PH_WRITE: if (tick) begin
                              if (wcnt == '0) phase <= PH_TRAIL;
                              else            wcnt  <= wcnt - 1'b1;
                          end
                PH_TRAIL: if (tick) phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ext_wr_seq.sv
module ext_wr_seq
    import ewb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_space,
    output logic              req_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_data_oe,
    output logic              bus_rnw,
    output logic              bus_mstrb_n,
    output logic              bus_iostrb_n,
    output logic              bus_ps_n,
    output logic              bus_ds_n,
    output logic              bus_is_n,
    output logic              clk_en
);
    wreq_t  cur;
    wcfg_t  cfg;
    phase_e phase;
    logic   accept;
    logic   tick;
    logic   need_bank;
    logic   active;
    logic   drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{addr: '0, data: '0, space: SP_PROG};
            cfg <= '0;
        end else if (accept) begin
            cur <= '{addr: req_addr, data: req_data, space: space_e'(req_space)};
            cfg <= '{div_code: cfg_div, wait_eff: clamp_wait(cfg_wait)};
        end
    end

    ewb_bank_track u_bank (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .addr        (req_addr),
        .need_switch (need_bank)
    );

    ewb_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (phase != PH_IDLE),
        .div_code (cfg.div_code),
        .tick     (tick)
    );

    ewb_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .tick      (tick),
        .need_bank (need_bank),
        .wait_eff  (cfg.wait_eff),
        .phase     (phase),
        .accept    (accept),
        .ack       (req_ack)
    );

    assign active = (phase == PH_LEAD) || (phase == PH_WRITE) || (phase == PH_TRAIL);
    assign drive  = (phase == PH_WRITE) || (phase == PH_TRAIL);

    assign bus_addr     = cur.addr;
    assign bus_data     = drive ? cur.data : '0;
    assign bus_data_oe  = drive;
    assign bus_rnw      = !active;
    assign bus_mstrb_n  = !((phase == PH_WRITE) && !space_is_io(cur.space));
    assign bus_iostrb_n = !((phase == PH_WRITE) &&  space_is_io(cur.space));
    assign bus_ps_n     = !(active && (cur.space == SP_PROG));
    assign bus_ds_n     = !(active && ((cur.space == SP_DATA) || (cur.space == SP_RSVD)));
    assign bus_is_n     = !(active && (cur.space == SP_IO));
    assign clk_en       = (phase != PH_IDLE) || req_valid;
endmodule

// File: rtl/ewb_checker.sv
module ewb_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_ack,
    input logic [22:0] bus_addr,
    input logic        bus_data_oe,
    input logic        bus_rnw,
    input logic        bus_mstrb_n,
    input logic        bus_iostrb_n,
    input logic        bus_ps_n,
    input logic        bus_ds_n,
    input logic        bus_is_n,
    input logic        clk_en
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!bus_mstrb_n && !bus_iostrb_n)); // R6
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack); // R8
    AST_STROBE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!bus_mstrb_n || !bus_iostrb_n) |-> (!bus_rnw && bus_data_oe)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> (bus_rnw && bus_mstrb_n && bus_iostrb_n && bus_ps_n && bus_ds_n && bus_is_n && !bus_data_oe)); // R1
    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (clk_en && bus_rnw) |-> (bus_mstrb_n && bus_iostrb_n && bus_ps_n && bus_ds_n && bus_is_n)); // R5
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!bus_rnw && !$past(bus_rnw)) |-> $stable(bus_addr)); // R8
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        !bus_rnw |-> ($countones({bus_ps_n, bus_ds_n, bus_is_n}) == 2)); // R6
endmodule

bind ext_wr_seq ewb_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ack      (req_ack),
    .bus_addr     (bus_addr),
    .bus_data_oe  (bus_data_oe),
    .bus_rnw      (bus_rnw),
    .bus_mstrb_n  (bus_mstrb_n),
    .bus_iostrb_n (bus_iostrb_n),
    .bus_ps_n     (bus_ps_n),
    .bus_ds_n     (bus_ds_n),
    .bus_is_n     (bus_is_n),
    .clk_en       (clk_en)
);

// File: tb/sim_ext_wr_seq.sv
`timescale 1ns/1ps
module sim_ext_wr_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_div = '0;
    logic [3:0]  cfg_wait = '0;
    logic        req_valid = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [1:0]  req_space = '0;
    logic        req_ack;
    logic [22:0] bus_addr;
    logic [15:0] bus_data;
    logic        bus_data_oe, bus_rnw, bus_mstrb_n, bus_iostrb_n;
    logic        bus_ps_n, bus_ds_n, bus_is_n, clk_en;

    int checks = 0;
    int fails  = 0;
    logic [7:0] last_region = '0;
    logic       have_region = 1'b0;

    always #2.5 clk = ~clk;

    ext_wr_seq u0 (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_wait(cfg_wait),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_space(req_space), .req_ack(req_ack), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_data_oe(bus_data_oe), .bus_rnw(bus_rnw),
        .bus_mstrb_n(bus_mstrb_n), .bus_iostrb_n(bus_iostrb_n),
        .bus_ps_n(bus_ps_n), .bus_ds_n(bus_ds_n), .bus_is_n(bus_is_n),
        .clk_en(clk_en)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // observed class: 0 idle, 1 bank, 2 lead, 3 write, 4 trail
    function automatic int classify();
        if (!clk_en) return 0;
        if (bus_rnw) return 1;
        if (!bus_mstrb_n || !bus_iostrb_n) return 3;
        if (bus_data_oe) return 4;
        return 2;
    endfunction

    task automatic do_write(input logic [22:0] a, input logic [15:0] d,
                            input int sp, input int dv, input int wt);
        int dfac, weff, b, len, k, ph_err, bank_n, wr_n, strb_err, sel_err, dat_err, adr_err, ack_at;
        dfac = dv + 1;
        weff = (wt > 14) ? 14 : wt;
        b = (!have_region || a[22:15] != last_region) ? 1 : 0;
        last_region = a[22:15];
        have_region = 1'b1;
        len = dfac * (b + 3 + weff);
        ph_err = 0; bank_n = 0; wr_n = 0; strb_err = 0; sel_err = 0;
        dat_err = 0; adr_err = 0; ack_at = -1;
        cfg_div = 2'(dv); cfg_wait = 4'(wt);
        req_addr = a; req_data = d; req_space = 2'(sp);
        req_valid = 1'b1;
        #0.5;
        chk(clk_en == 1'b1, "R9 clk_en on request", int'(clk_en), 1);
        for (k = 0; k < 300; k++) begin
            int q, exp_c, obs;
            @(negedge clk);
            if (k == 1) begin
                req_addr = ~a; req_data = ~d; req_space = 2'(2 - sp);
                cfg_div = 2'(3 - dv); cfg_wait = 4'(15 - wt);
            end
            q = k / dfac;
            if (b == 1 && q == 0) exp_c = 1;
            else if (q - b == 0) exp_c = 2;
            else if (q - b <= 1 + weff) exp_c = 3;
            else exp_c = 4;
            obs = classify();
            if (obs != exp_c) ph_err++;
            if (obs == 1) bank_n++;
            if (obs == 3) begin
                wr_n++;
                if ((sp == 2) ? (bus_iostrb_n || !bus_mstrb_n) : (bus_mstrb_n || !bus_iostrb_n))
                    strb_err++;
            end
            if (obs >= 2) begin
                if (bus_ps_n != (sp != 0) || bus_ds_n != (sp != 1) || bus_is_n != (sp != 2))
                    sel_err++;
                if (bus_addr != a) adr_err++;
            end else if (obs == 1) begin
                if (!bus_ps_n || !bus_ds_n || !bus_is_n) sel_err++;
            end
            if (obs >= 3 && (bus_data != d || !bus_data_oe)) dat_err++;
            if (req_ack) begin
                ack_at = k;
                req_valid = 1'b0;
                break;
            end
        end
        chk(ph_err == 0, "R2 R3 R4 phase pattern mismatches", ph_err, 0);
        chk(ack_at == len - 1, "R4 R8 ack cycle (total length-1)", ack_at, len - 1);
        chk(bank_n == dfac * b, "R5 bank-switch clocks", bank_n, dfac * b);
        chk(wr_n == dfac * (1 + weff), "R3 write-phase clocks", wr_n, dfac * (1 + weff));
        chk(strb_err == 0, "R6 strobe choice errors", strb_err, 0);
        chk(sel_err == 0, "R6 space select errors", sel_err, 0);
        chk(dat_err == 0, "R7 data drive errors", dat_err, 0);
        chk(adr_err == 0, "R8 address held errors", adr_err, 0);
        @(negedge clk);
        chk(!clk_en && !req_ack && bus_rnw, "R9 idle after ack", int'(clk_en), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int widx;
        int waits [6] = '{0, 1, 2, 5, 14, 15};
        widx = 0;
        repeat (4) @(negedge clk);
        chk(bus_rnw && bus_mstrb_n && bus_iostrb_n && bus_ps_n && bus_ds_n && bus_is_n
            && !bus_data_oe && !req_ack && !clk_en, "R1 reset outputs", int'(bus_rnw), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(!clk_en && bus_rnw && bus_mstrb_n, "R1 idle after reset", int'(clk_en), 0);
        // first access always switches bank, base case R2
        do_write(23'h000123, 16'hA5C3, 1, 0, 0);
        for (int dv = 0; dv < 4; dv++) begin
            for (int wi = 0; wi < 6; wi++) begin
                for (int sp = 0; sp < 3; sp++) begin
                    logic [7:0] reg8;
                    reg8 = 8'((widx / 2) * 37 + 1);
                    do_write({reg8, 15'(widx * 911 + 5)}, 16'(widx * 4099 + 17), sp, dv, waits[wi]);
                    widx++;
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule